// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a free-running periodic tick source that software programs over a small register bus. A 20-bit counter counts clock cycles up to a programmed period and then returns to zero. Each completed period raises a status flag and increments a 12-bit count of periods that have not yet been acknowledged. If software is slow to service the interrupt, it can still recover the exact elapsed time as (unacknowledged periods × cycles per period) plus the current counter value.

The same two counters can be read through two windows. One window acknowledges: reading it clears the flag and the period count. The other window is a snapshot with no side effects, so timekeeping code can sample elapsed time at any moment without disturbing interrupt handling. A level interrupt output is the status flag gated by an interrupt enable bit. Before software re-arms the timer, it should drain stale pending state with one read of the acknowledging window.

Top module: `ptick_timer`

## Requirements
- R1: The control word at offset 0x00 holds the period in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. It reads back exactly as written, and all other bits read as 0.
- R2: While the run enable is set, the counter increments by one on every clock. On the clock after it reaches the period (count >= period), it returns to 0, so a period value P gives P+1 cycles per wrap.
- R3: Every wrap sets the status flag (bit 0 at offset 0x04) and increments the period count. The period count saturates at 4095.
- R4: A read at offset 0x08 returns the period count in bits 31:20 and the counter in bits 19:0. The read clears the status flag and the period count at the end of its cycle.
- R5: If a wrap occurs in the same cycle as a read at 0x08, the period count becomes 1 and the status flag stays set.
- R6: A read at offset 0x0C returns the same layout as 0x08 and changes no state.
- R7: The interrupt output is high exactly when the status flag and the interrupt enable are both set.
- R8: While the run enable is clear, the counter is held at 0 and the period count and status flag are retained. After the enable is set again, counting restarts from 0.
- R9: Reset clears all state. Reads of any other offset, and any cycle without a read strobe, return 0. Writes to offsets other than 0x00 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that a read strobe lasts one cycle per access and that write and read strobes are never raised together. The bench drives exactly one operation per clock slot to meet this. The properties also assume that reads of 0x08 are the only acknowledge, so a one-cycle acknowledge pulse is exact. The stimulus covers the corner cases where timing matters: a period change while the counter runs, an acknowledge that coincides with a wrap, disabling in the same cycle as a wrap, and a period of 0. Expected counter values are derived by counting clock edges from the write that enabled the timer.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = 20;
    localparam int ICNT_W   = 12;
    localparam int RUN_BIT  = 24;
    localparam int IEN_BIT  = 25;
    localparam int ICNT_LSB = DATA_W - ICNT_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SNAP  = 5'h0C;

    typedef struct packed {
        logic             ien;
        logic             run;
        logic [CNT_W-1:0] period;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_W-1:0] = c.period;
        w[RUN_BIT]   = c.run;
        w[IEN_BIT]   = c.ien;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.period = w[CNT_W-1:0];
        c.run    = w[RUN_BIT];
        c.ien    = w[IEN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_count(
        input logic [ICNT_W-1:0] icnt, input logic [CNT_W-1:0] cnt);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1:ICNT_LSB] = icnt;
        w[CNT_W-1:0]         = cnt;
        return w;
    endfunction
endpackage

// File: rtl/ptick_ctrl_reg.sv
module ptick_ctrl_reg
    import ptick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst)        ctrl <= '0;
        else if (wr_en) ctrl <= unpack_ctrl(wdata);
    end
endmodule

// File: rtl/ptick_counter.sv
module ptick_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = run && (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (wrap)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ptick_accum.sv
module ptick_accum #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic         ack,
    output logic [W-1:0] icnt,
    output logic         pending
);
    localparam logic [W-1:0] ICNT_MAX = '1;

    logic [W-1:0] icnt_inc;
    assign icnt_inc = (icnt == ICNT_MAX) ? ICNT_MAX : icnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            icnt    <= '0;
            pending <= 1'b0;
        end else if (wrap) begin
            icnt    <= ack ? W'(1) : icnt_inc;
            pending <= 1'b1;
        end else if (ack) begin
            icnt    <= '0;
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
    import ptick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [ICNT_W-1:0] icnt;
    logic              pending;
    logic              ctrl_wr;
    logic              ack;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign ack     = bus_rd && (bus_addr == OFS_ACK);

    ptick_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(bus_wdata), .ctrl(ctrl)
    );

    ptick_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .period(ctrl.period),
        .cnt(cnt), .wrap(wrap)
    );

    ptick_accum #(.W(ICNT_W)) u_acc (
        .clk(clk), .rst(rst), .wrap(wrap), .ack(ack),
        .icnt(icnt), .pending(pending)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = pack_ctrl(ctrl);
                OFS_STAT: bus_rdata = DATA_W'(pending);
                OFS_ACK,
                OFS_SNAP: bus_rdata = pack_count(icnt, cnt);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = pending && ctrl.ien;
endmodule

// File: rtl/ptick_timer_chk.sv
module ptick_timer_chk
    import ptick_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt,
    input logic              wrap,
    input logic              ack,
    input logic [ICNT_W-1:0] icnt,
    input logic              pending
);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> cnt == '0);

    p_wrap_sets_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> pending && icnt != '0);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && !wrap) |=> (!pending && icnt == '0));

    p_ack_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && wrap) |=> (pending && icnt == ICNT_W'(1)));

    p_icnt_mono_r3: assert property (@(posedge clk) disable iff (rst)
        !ack |=> icnt >= $past(icnt));

    p_irq_mask_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.ien && pending));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || (bus_addr != OFS_CTRL && bus_addr != OFS_STAT &&
                     bus_addr != OFS_ACK && bus_addr != OFS_SNAP))
        |-> bus_rdata == '0);
endmodule

bind ptick_timer ptick_timer_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq), .ctrl(ctrl), .cnt(cnt),
    .wrap(wrap), .ack(ack), .icnt(icnt), .pending(pending)
);

// File: tb/ptick_timer_test.sv
`timescale 1ns/1ps
module ptick_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int applied = 0;
    int misses  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [4:0]  addr;
        logic [31:0] data;
        logic        irq;
        string       req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    ptick_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] cw(int period, bit run, bit ien);
        return {6'b0, ien, run, 4'b0, 20'(period)};
    endfunction

    function automatic logic [31:0] cv(int icnt, int cnt);
        return {12'(icnt), 20'(cnt)};
    endfunction

    task automatic op_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic op_read(logic [4:0] a, logic [31:0] d, logic ei, string req);
        item_t it;
        @(negedge clk);
        it.addr = a; it.data = d; it.irq = ei; it.req = req;
        sb.push_back(it);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    endtask

    task automatic op_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
        end
    endtask

    // Monitor: compares each read against the head of the scoreboard
    always @(negedge clk) begin
        #2;
        if (bus_rd && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            applied++;
            if (bus_rdata !== it.data || irq !== it.irq) begin
                misses++;
                $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.req, it.addr, bus_rdata, irq, it.data, it.irq);
            end
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired, run did not complete");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state and unmapped offset
        op_read(5'h00, 32'h0, 1'b0, "R9 ctrl after reset");
        op_read(5'h04, 32'h0, 1'b0, "R9 status after reset");
        op_read(5'h08, 32'h0, 1'b0, "R9 ack view after reset");
        op_read(5'h0C, 32'h0, 1'b0, "R9 snapshot after reset");
        op_read(5'h14, 32'h0, 1'b0, "R9 unmapped offset");
        // R1 R2 R3: period 4 -> 5 cycles per wrap
        op_write(5'h00, cw(4, 1, 1));
        op_read(5'h0C, cv(0, 0), 1'b0, "R2 count starts at 0");
        op_read(5'h00, 32'h0300_0004, 1'b0, "R1 ctrl readback");
        op_idle(3);
        op_read(5'h0C, cv(1, 0), 1'b1, "R3 first wrap");
        op_read(5'h04, 32'h1, 1'b1, "R3 status set");
        op_read(5'h0C, cv(1, 2), 1'b1, "R6 snapshot has no side effect");
        op_idle(4);
        // R4 acknowledge read
        op_read(5'h08, cv(2, 2), 1'b1, "R4 ack read value");
        op_read(5'h0C, cv(0, 3), 1'b0, "R4 cleared after ack");
        // R5 ack coinciding with wrap
        op_read(5'h08, cv(0, 4), 1'b0, "R5 ack at wrap cycle");
        op_read(5'h04, 32'h1, 1'b1, "R5 status kept");
        op_read(5'h0C, cv(1, 1), 1'b1, "R5 one period kept");
        // R7 masking
        op_write(5'h00, cw(4, 1, 0));
        op_read(5'h04, 32'h1, 1'b0, "R7 irq masked");
        // R8 disable in the wrap cycle
        op_write(5'h00, 32'h0);
        op_read(5'h0C, cv(2, 0), 1'b0, "R8 disabled counter at 0");
        op_idle(3);
        op_read(5'h0C, cv(2, 0), 1'b0, "R8 held while disabled");
        // R9 writes to other offsets ignored
        op_write(5'h04, 32'h0);
        op_read(5'h04, 32'h1, 1'b0, "R9 status write ignored");
        op_write(5'h0C, 32'hFFFF_FFFF);
        op_read(5'h0C, cv(2, 0), 1'b0, "R9 snapshot write ignored");
        op_read(5'h08, cv(2, 0), 1'b0, "R4 drain before re-arm");
        op_read(5'h04, 32'h0, 1'b0, "R4 status clear after drain");
        // R8 re-enable from 0, period 2 -> 3 cycles
        op_write(5'h00, cw(2, 1, 1));
        op_read(5'h0C, cv(0, 0), 1'b0, "R8 restart from 0");
        op_idle(2);
        op_read(5'h0C, cv(1, 0), 1'b1, "R2 period 2 wrap");
        op_read(5'h08, cv(1, 1), 1'b1, "R4 ack period 2");
        op_read(5'h04, 32'h0, 1'b0, "R7 irq drops after ack");
        // R3 saturation with period 0
        op_write(5'h00, cw(0, 1, 1));
        op_idle(4200);
        op_read(5'h0C, cv(4095, 0), 1'b1, "R3 saturated count");
        op_read(5'h08, cv(4095, 0), 1'b1, "R4 ack saturated");
        op_read(5'h0C, cv(1, 0), 1'b1, "R5 ack with wrap each cycle");
        op_idle(2);
        done = 1'b1;
        if (sb.size() != 0) begin
            misses++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        report();
    end
endmodule